// File: doc/BRIEF.md
# Dual-Channel Serial Converter Sequencer

This block is the host-side sequencer for a 16-bit, two-input analog-to-digital converter. The converter needs a conversion strobe, a shift clock, a serial input that carries a 2-bit multiplexer word, and a serial output that returns the result. On a start request the host supplies a channel configuration. The sequencer gives the converter a clean rising edge on the strobe and holds the strobe high for a parameterised number of system clocks, which is the conversion time. It then drops the strobe and runs 16 shift-clock periods. During these it sends the configuration word and collects the 16-bit result, most significant bit first.

The configuration word takes effect for the conversion that follows, not the one being read out. For this reason the sequencer reports, next to every result, the configuration that was actually in effect when that result was sampled. This is the word sent during the previous transfer, or a reset default for the first transfer. After the last bit the strobe goes back high and the converter sleeps until the next request. The shift clock is derived from the system clock through a parameterised half-period divider and stays low whenever the strobe is high.

Top module: `twin_adc_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, adc_conv_o, adc_sck_o, adc_din_o, result_valid_o and busy_o are all 0, and {result_single_o, result_odd_o} equals RESET_CFG (default single=1, odd=0).
- R2: A start_i sampled high while busy_o is 0 is accepted. busy_o is 1 from the next clock, adc_conv_o is 0 for exactly one clock after acceptance, and adc_conv_o is 1 in the clock after that.
- R3: Once raised for a transfer, adc_conv_o stays 1 for exactly CONV_CYCLES system clocks before it is driven low. adc_sck_o is 0 in every cycle in which adc_conv_o is 1.
- R4: After adc_conv_o falls, adc_sck_o stays low for SCK_HALF clocks, and every later high or low phase also lasts SCK_HALF clocks. Exactly 16 rising edges of adc_sck_o occur per transfer.
- R5: The bit on adc_din_o at the first rising shift-clock edge is the requested single-ended flag (req_single_i). The bit at the second is the odd/sign flag (req_odd_i). At the remaining 14 rising edges it is 0. adc_din_o changes only while adc_sck_o is low.
- R6: adc_dout_i is sampled on each rising shift-clock edge, and result_o holds the 16 samples with the first one as bit 15.
- R7: SCK_HALF clocks after the 16th rising edge, in a single cycle, adc_sck_o goes low, adc_conv_o goes high, busy_o goes low and result_valid_o is 1. result_valid_o is 1 for exactly one clock.
- R8: With each valid pulse, {result_single_o, result_odd_o} equals the configuration sent in the previous transfer, or RESET_CFG for the first transfer after reset. The configuration encoding is: single=1, odd=0 selects input 0 against ground; single=1, odd=1 selects input 1 against ground; single=0 selects differential mode, with odd choosing which input is positive.
- R9: A start_i asserted while busy_o is 1 is ignored. No additional transfer follows, and the configuration given with it is never sent.
- R10: Between transfers, adc_conv_o remains 1 and adc_sck_o remains 0 until the next accepted start.
- R11: result_o and the reported configuration change only in a cycle in which result_valid_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a conversion and readout |
| req_single_i | input | 1 | Requested mode flag: 1 single-ended, 0 differential |
| req_odd_i | input | 1 | Requested odd/sign flag |
| busy_o | output | 1 | Transfer in progress; start is ignored while 1 |
| adc_conv_o | output | 1 | Conversion strobe to the converter |
| adc_sck_o | output | 1 | Shift clock to the converter |
| adc_din_o | output | 1 | Serial configuration bit to the converter |
| adc_dout_i | input | 1 | Serial result bit from the converter |
| result_o | output | 16 | Last collected result |
| result_valid_o | output | 1 | One-clock pulse when result_o is updated |
| result_single_o | output | 1 | Mode flag in effect for result_o |
| result_odd_o | output | 1 | Odd/sign flag in effect for result_o |

## Verification
The bench attaches a behavioural converter that shifts a known word out on falling shift-clock edges and records the configuration bits at rising edges. This exposes a sequencer that samples on the wrong edge, since its result would come back shifted by one bit. Results of all zeros, all ones and alternating end bits make a swapped bit order or a lost first bit visible. Each result is compared with the configuration from the previous transfer rather than the current one, so a design that reported the request just made would fail every transfer whose configuration differs from its predecessor. Start pulses held during a busy transfer catch a sequencer that restarts, or that latches the late configuration. Phase-width and strobe-duration counts catch an off-by-one in either timer.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_CONV  = 2'd2,
        ST_SHIFT = 2'd3
    } ctrl_state_e;

    // Multiplexer word, sent single first then odd.
    typedef struct packed {
        logic single;
        logic odd;
    } mux_cfg_t;

endpackage

// File: rtl/adc_interval.sv
// Free-running interval counter: pulses expire_o every LIMIT enabled clocks.
module adc_interval #(
    parameter int LIMIT = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = run_i && (cnt_q == LAST);
        if (!run_i || expire_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_frame_shift.sv
// Transmit and receive shift registers for one serial frame.
module adc_frame_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_word_i,
    input  logic              tx_step_i,
    input  logic              rx_step_i,
    input  logic              rx_bit_i,
    output logic              tx_bit_o,
    output logic [DATA_W-1:0] rx_word_o
);
    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } shift_t;

    shift_t d, q;

    always_comb begin
        d = q;
        if (load_i) begin
            d.tx = load_word_i;
        end else if (tx_step_i) begin
            d.tx = {q.tx[DATA_W-2:0], 1'b0};
        end
        if (rx_step_i) begin
            d.rx = {q.rx[DATA_W-2:0], rx_bit_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tx_bit_o  = q.tx[DATA_W-1];
    assign rx_word_o = q.rx;
endmodule

// File: rtl/twin_adc_ctrl.sv
module twin_adc_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int       DATA_W      = 16,
    parameter int       SCK_HALF    = 2,
    parameter int       CONV_CYCLES = 20,
    parameter mux_cfg_t RESET_CFG   = '{single: 1'b1, odd: 1'b0}
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              req_single_i,
    input  logic              req_odd_i,
    output logic              busy_o,
    output logic              adc_conv_o,
    output logic              adc_sck_o,
    output logic              adc_din_o,
    input  logic              adc_dout_i,
    output logic [DATA_W-1:0] result_o,
    output logic              result_valid_o,
    output logic              result_single_o,
    output logic              result_odd_o
);
    localparam int CFG_W = $bits(mux_cfg_t);
    localparam int EW    = $clog2(DATA_W + 1);
    localparam logic [EW-1:0] LAST_EDGE = EW'(DATA_W);

    typedef struct packed {
        ctrl_state_e       st;
        mux_cfg_t          req;      // word to send this transfer
        mux_cfg_t          live;     // word governing the running conversion
        mux_cfg_t          res_cfg;  // word reported with result
        logic              conv;
        logic              sck;
        logic [EW-1:0]     edges;
        logic [DATA_W-1:0] res;
        logic              valid;
    } regs_t;

    regs_t d, q;

    logic              wait_run, wait_done;
    logic              half_run, half_done;
    logic              load, tx_step, rx_step;
    logic              tx_bit;
    logic [DATA_W-1:0] rx_word;
    logic [DATA_W-1:0] load_word;

    assign wait_run  = (q.st == ST_CONV);
    assign half_run  = (q.st == ST_SHIFT);
    assign load_word = {q.req, {(DATA_W - CFG_W){1'b0}}};

    adc_interval #(.LIMIT(CONV_CYCLES)) u_conv_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (wait_run),
        .expire_o (wait_done)
    );

    adc_interval #(.LIMIT(SCK_HALF)) u_half_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (half_run),
        .expire_o (half_done)
    );

    adc_frame_shift #(.DATA_W(DATA_W)) u_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load),
        .load_word_i (load_word),
        .tx_step_i   (tx_step),
        .rx_step_i   (rx_step),
        .rx_bit_i    (adc_dout_i),
        .tx_bit_o    (tx_bit),
        .rx_word_o   (rx_word)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        load    = 1'b0;
        tx_step = 1'b0;
        rx_step = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.req.single = req_single_i;
                    d.req.odd    = req_odd_i;
                    d.conv       = 1'b0;   // guarantee a fresh rising edge
                    d.st         = ST_ARM;
                end
            end
            ST_ARM: begin
                d.conv = 1'b1;
                d.st   = ST_CONV;
            end
            ST_CONV: begin
                if (wait_done) begin
                    d.conv  = 1'b0;
                    d.edges = '0;
                    load    = 1'b1;
                    d.st    = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (half_done) begin
                    if (!q.sck) begin
                        d.sck   = 1'b1;
                        rx_step = 1'b1;
                        d.edges = q.edges + EW'(1);
                    end else if (q.edges == LAST_EDGE) begin
                        d.sck     = 1'b0;
                        d.conv    = 1'b1;
                        d.valid   = 1'b1;
                        d.res     = rx_word;
                        d.res_cfg = q.live;
                        d.live    = q.req;
                        d.edges   = '0;
                        d.st      = ST_IDLE;
                    end else begin
                        d.sck   = 1'b0;
                        tx_step = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q         <= '0;
            q.req     <= RESET_CFG;
            q.live    <= RESET_CFG;
            q.res_cfg <= RESET_CFG;
        end else begin
            q <= d;
        end
    end

    assign busy_o          = (q.st != ST_IDLE);
    assign adc_conv_o      = q.conv;
    assign adc_sck_o       = q.sck;
    assign adc_din_o       = tx_bit;
    assign result_o        = q.res;
    assign result_valid_o  = q.valid;
    assign result_single_o = q.res_cfg.single;
    assign result_odd_o    = q.res_cfg.odd;
endmodule

// File: rtl/twin_adc_ctrl_chk.sv
module twin_adc_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              busy_o,
    input logic              adc_conv_o,
    input logic              adc_sck_o,
    input logic              adc_din_o,
    input logic [DATA_W-1:0] result_o,
    input logic              result_valid_o,
    input logic              result_single_o,
    input logic              result_odd_o
);
    AST_SCK_QUIET_IN_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adc_conv_o |-> !adc_sck_o);  // R3

    AST_ACCEPT_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !busy_o |=> busy_o && !adc_conv_o);  // R2

    AST_VALID_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        result_valid_o |=> !result_valid_o);  // R7

    AST_VALID_AT_FINISH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        result_valid_o |-> adc_conv_o && !busy_o && !adc_sck_o && $past(busy_o));  // R7

    AST_DIN_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adc_sck_o && $past(adc_sck_o) |-> $stable(adc_din_o));  // R5

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !adc_sck_o);  // R10

    AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !result_valid_o |-> $stable(result_o) && $stable(result_single_o)
                            && $stable(result_odd_o));  // R11
endmodule

bind twin_adc_ctrl twin_adc_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (start_i),
    .busy_o          (busy_o),
    .adc_conv_o      (adc_conv_o),
    .adc_sck_o       (adc_sck_o),
    .adc_din_o       (adc_din_o),
    .result_o        (result_o),
    .result_valid_o  (result_valid_o),
    .result_single_o (result_single_o),
    .result_odd_o    (result_odd_o)
);

// File: tb/twin_adc_ctrl_test.sv
module twin_adc_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int HALF       = 3;
    localparam int CONVW      = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, rs = 1'b0, ro = 1'b0;
    logic busy, conv, sck, din, valid, res_s, res_o;
    logic adc_sdi = 1'b0;
    logic [W-1:0] res;

    always #(CLK_PERIOD/2) clk = ~clk;

    twin_adc_ctrl #(.DATA_W(W), .SCK_HALF(HALF), .CONV_CYCLES(CONVW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .req_single_i(rs), .req_odd_i(ro), .busy_o(busy),
        .adc_conv_o(conv), .adc_sck_o(sck), .adc_din_o(din), .adc_dout_i(adc_sdi),
        .result_o(res), .result_valid_o(valid),
        .result_single_o(res_s), .result_odd_o(res_o)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] din_pattern(input logic [1:0] cfg);
        return {cfg, {(W-2){1'b0}}};
    endfunction

    // Converter model and link monitor, sampled at the falling system clock.
    logic [W-1:0] adc_word = '0;
    int adc_idx = 0;
    logic prev_conv = 0, prev_sck = 0, prev_din = 0, prev_valid = 0;
    logic [W-1:0] prev_res = '0;
    int conv_hi_run = 0, conv_hi_at_fall = 0, sck_run = 0, rises = 0, total_rises = 0;
    logic [W-1:0] din_bits = '0;
    bit width_bad = 0, sck_in_conv = 0, din_glitch = 0, valid_bad = 0, hold_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (conv) conv_hi_run++;
            if (prev_conv && !conv) begin
                conv_hi_at_fall = conv_hi_run;
                conv_hi_run = 0;
                sck_run = 1;
                rises = 0;
                din_bits = '0;
                adc_sdi = adc_word[W-1];
                adc_idx = W - 2;
            end else if (sck != prev_sck) begin
                if (sck_run != HALF) width_bad = 1;
                sck_run = 1;
            end else begin
                sck_run++;
            end
            if (sck && !prev_sck) begin
                rises++;
                total_rises++;
                din_bits = {din_bits[W-2:0], din};
            end
            if (!sck && prev_sck && !conv) begin
                adc_sdi = (adc_idx >= 0) ? adc_word[adc_idx] : 1'b0;
                adc_idx--;
            end
            if (conv && sck) sck_in_conv = 1;
            if (sck && prev_sck && din != prev_din) din_glitch = 1;
            if (valid && prev_valid) valid_bad = 1;
            if (!valid && res != prev_res) hold_bad = 1;
        end
        prev_conv = conv; prev_sck = sck; prev_din = din;
        prev_valid = valid; prev_res = res;
    end

    logic [1:0] prev_cfg = 2'b10;
    int nxfer = 0;

    task automatic xfer(input logic [1:0] cfg, input logic [W-1:0] word, input bit poke);
        logic [1:0] exp_cfg;
        while (busy) @(negedge clk);
        adc_word = word;
        width_bad = 0; sck_in_conv = 0; din_glitch = 0;
        rs = cfg[1]; ro = cfg[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", busy, 1);
        check(conv == 1'b0, "R2 strobe low one clock", conv, 0);
        @(negedge clk);
        check(conv == 1'b1, "R2 strobe rises", conv, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            rs = ~cfg[1]; ro = ~cfg[0]; start = 1'b1;
            repeat (3) @(negedge clk);
            start = 1'b0;
        end
        while (!valid) @(negedge clk);
        exp_cfg = prev_cfg;
        prev_cfg = cfg;
        nxfer++;
        check(res == word, "R6 result", res, word);
        check({res_s, res_o} == exp_cfg, "R8 reported config", {res_s, res_o}, exp_cfg);
        check(din_bits == din_pattern(cfg), "R5 config bits", din_bits, din_pattern(cfg));
        check(!din_glitch, "R5 din stable while sck high", din_glitch, 0);
        check(rises == W, "R4 rising edge count", rises, W);
        check(!width_bad, "R4 phase width", width_bad, 0);
        check(conv_hi_at_fall == CONVW, "R3 strobe high time", conv_hi_at_fall, CONVW);
        check(!sck_in_conv, "R3 sck low while strobe high", sck_in_conv, 0);
        check(conv && !sck && !busy, "R7 finish state", {conv, sck, busy}, 3'b100);
        @(negedge clk);
        check(!valid && !valid_bad, "R7 valid one clock", valid, 0);
        if (poke) begin
            repeat (2*HALF + CONVW + 4) @(negedge clk);
            check(!busy && total_rises == W*nxfer, "R9 busy start ignored", total_rises, W*nxfer);
            check(conv && !sck, "R10 idle strobe high sck low", {conv, sck}, 2'b10);
        end
    endtask

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (4) @(negedge clk);
        check(!conv && !sck && !din && !valid && !busy, "R1 reset outputs",
              {conv, sck, din, valid, busy}, 0);
        check({res_s, res_o} == 2'b10, "R1 reset config", {res_s, res_o}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(!conv && !sck && !busy, "R1 after reset", {conv, sck, busy}, 0);
        xfer(2'b10, 16'h0000, 1'b0);
        xfer(2'b11, 16'hFFFF, 1'b0);
        xfer(2'b00, 16'h8001, 1'b1);
        xfer(2'b01, 16'h7FFE, 1'b0);
        for (int i = 0; i < 30; i++) begin
            logic [1:0] c;
            logic [W-1:0] w;
            c = 2'($urandom % 4);
            w = W'($urandom);
            repeat ($urandom % 4) @(negedge clk);
            xfer(c, w, ($urandom % 5) == 0);
        end
        check(!hold_bad, "R11 result held between pulses", hold_bad, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule